// File: doc/BRIEF.md
# Floating-Point Add/Subtract Sequencer

This unit adds or subtracts two floating-point operands over several clock cycles. Each operand has three parts: a sign bit, an unsigned fraction magnitude and a biased exponent. The magnitude is a pure fraction, and it is normalized when its top bit is 1. The first operand sits in an accumulator and the second in an operand register. The result replaces the accumulator contents, and the output ports show the accumulator at all times.

A caller presents both operands and the operation select, then raises `start` while the unit is idle. The unit first handles zero operands on an early-exit path. Otherwise it equalizes the exponents one bit-shift per cycle. It then combines the magnitudes under signed-magnitude rules and renormalizes the result one position per cycle. When it finishes, it pulses `done`. Operands are assumed normalized or zero, and a zero mantissa marks a zero operand. There is no rounding and there are no guard bits: bits shifted out during alignment are lost.

Top module: `fpas_seq`

## Requirements
- R1: After reset, `busy`, `done` and `exp_uflow` are 0, and the result sign, mantissa and exponent are all 0.
- R2: When the second operand's mantissa is 0, the operation ends without changing the accumulator, so the result equals the first operand exactly.
- R3: When the first operand's mantissa is 0 and the second's is not, the result is the second operand. Its sign is inverted when `op_sub` is 1 (subtract); `op_sub` = 0 means add.
- R4: While the exponents differ, the operand with the smaller exponent shifts its mantissa right by one bit and raises its exponent by one in each cycle. Alignment adjusts exactly one exponent per cycle, and the result exponent before normalization is the larger exponent.
- R5: When the first sign equals the effective second sign, the magnitudes are added and the result takes the first sign. The effective second sign is the second sign XOR `op_sub`, with sign 1 meaning negative. A carry out of the add shifts the sum right with the carry entering the top bit and raises the exponent by one.
- R6: When the signs differ, the smaller magnitude is subtracted from the larger and the result takes the sign of the larger. If the magnitudes are equal, sign, mantissa and exponent are all cleared to 0.
- R7: After a subtraction, while the mantissa top bit is 0, the mantissa shifts left by one and the exponent drops by one per cycle until the top bit is 1.
- R8: If normalization needs a left shift while the exponent is already 0, `exp_uflow` is set and normalization stops. The flag stays set until the next accepted `start`, which clears it.
- R9: `busy` is high from the cycle after an accepted `start` until the operation ends. `done` is a single-cycle pulse, raised in the same cycle in which `busy` falls.
- R10: `start` is ignored while `busy` is high, so the operands presented with it have no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_sub | input | 1 | 1 = subtract second operand, 0 = add |
| a_sign | input | 1 | First operand sign (1 = negative) |
| a_mant | input | MANT_W | First operand fraction magnitude |
| a_exp | input | EXP_W | First operand biased exponent |
| b_sign | input | 1 | Second operand sign |
| b_mant | input | MANT_W | Second operand fraction magnitude |
| b_exp | input | EXP_W | Second operand biased exponent |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| r_sign | output | 1 | Accumulator sign |
| r_mant | output | MANT_W | Accumulator mantissa |
| r_exp | output | EXP_W | Accumulator exponent |
| exp_uflow | output | 1 | Sticky exponent-underflow flag |

## Verification
The bench targets the corner cases below, and each catches a specific design error:
- An alignment distance larger than the mantissa width, so the shifted mantissa becomes zero. A design that stopped shifting early, or shifted the wrong operand, would report the smaller exponent.
- An add that carries out. Dropping the carry would leave the sum off by half, at the wrong exponent.
- Equal magnitudes cancelling under subtraction. A design that kept the sign or the exponent would return a negative or scaled zero.
- A cancellation that needs four left shifts. A wrong per-shift exponent adjustment would show up in the result exponent.
- A normalization that runs into exponent 0, to check both the flag and its clearing on the next operation.
- The zero early exits, including the sign flip on subtract.
- A second `start`, carrying different operands, raised while the unit is busy. A design that reloaded its registers would return the wrong result.

// File: rtl/fpas_pkg.sv
package fpas_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ZCHK,
    ST_ALIGN,
    ST_ARITH,
    ST_NORM
  } fpas_state_e;

  typedef enum logic [1:0] {
    CMP_LT,
    CMP_EQ,
    CMP_GT
  } exp_cmp_e;

endpackage

// File: rtl/fpas_align.sv
module fpas_align
  import fpas_pkg::*;
#(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 6
) (
  input  logic [MANT_W-1:0] a_mant,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [MANT_W-1:0] b_mant,
  input  logic [EXP_W-1:0]  b_exp,
  output exp_cmp_e          cmp,
  output logic [MANT_W-1:0] a_mant_nx,
  output logic [EXP_W-1:0]  a_exp_nx,
  output logic [MANT_W-1:0] b_mant_nx,
  output logic [EXP_W-1:0]  b_exp_nx
);

  // Three-way exponent comparison.
  function automatic exp_cmp_e compare_exp(input logic [EXP_W-1:0] x,
                                           input logic [EXP_W-1:0] y);
    if (x < y)       return CMP_LT;
    else if (x == y) return CMP_EQ;
    else             return CMP_GT;
  endfunction

  always_comb begin
    cmp       = compare_exp(a_exp, b_exp);
    a_mant_nx = a_mant;
    a_exp_nx  = a_exp;
    b_mant_nx = b_mant;
    b_exp_nx  = b_exp;
    // One alignment step: the operand with the smaller exponent moves right.
    unique case (cmp)
      CMP_LT: begin
        a_mant_nx = a_mant >> 1;
        a_exp_nx  = a_exp + 1'b1;
      end
      CMP_GT: begin
        b_mant_nx = b_mant >> 1;
        b_exp_nx  = b_exp + 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fpas_mant_alu.sv
module fpas_mant_alu #(
  parameter int MANT_W = 8
) (
  input  logic              a_sign,
  input  logic [MANT_W-1:0] a_mant,
  input  logic              b_sign,
  input  logic [MANT_W-1:0] b_mant,
  input  logic              op_sub,
  output logic              res_sign,
  output logic [MANT_W-1:0] res_mant,
  output logic              carry,
  output logic              did_add
);

  localparam int SUM_W = MANT_W + 1;

  // Magnitude sum with carry out.
  function automatic logic [SUM_W-1:0] mag_add(input logic [MANT_W-1:0] x,
                                               input logic [MANT_W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  // x + ~y + 1: top bit set means x >= y.
  function automatic logic [SUM_W-1:0] mag_sub(input logic [MANT_W-1:0] x,
                                               input logic [MANT_W-1:0] y);
    return {1'b0, x} + {1'b0, ~y} + SUM_W'(1);
  endfunction

  logic             eff_b_sign;
  logic [SUM_W-1:0] sum_w;
  logic [SUM_W-1:0] dif_w;

  always_comb begin
    eff_b_sign = b_sign ^ op_sub;
    sum_w      = mag_add(a_mant, b_mant);
    dif_w      = mag_sub(a_mant, b_mant);
    did_add    = (a_sign == eff_b_sign);
    if (did_add) begin
      carry    = sum_w[MANT_W];
      res_mant = sum_w[MANT_W-1:0];
      res_sign = a_sign;
    end else begin
      carry = dif_w[MANT_W];
      if (dif_w[MANT_W]) begin
        res_mant = dif_w[MANT_W-1:0];
        res_sign = (dif_w[MANT_W-1:0] == '0) ? 1'b0 : a_sign;
      end else begin
        res_mant = ~dif_w[MANT_W-1:0] + 1'b1;
        res_sign = eff_b_sign;
      end
    end
  end

endmodule

// File: rtl/fpas_norm.sv
module fpas_norm #(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 6
) (
  input  logic              sign_in,
  input  logic [MANT_W-1:0] mant_in,
  input  logic [EXP_W-1:0]  exp_in,
  input  logic              e_bit,
  input  logic              was_add,
  output logic              sign_nx,
  output logic [MANT_W-1:0] mant_nx,
  output logic [EXP_W-1:0]  exp_nx,
  output logic              finished,
  output logic              sub_zero,
  output logic              uflow_hit
);

  always_comb begin
    sign_nx   = sign_in;
    mant_nx   = mant_in;
    exp_nx    = exp_in;
    finished  = 1'b0;
    sub_zero  = 1'b0;
    uflow_hit = 1'b0;
    if (was_add) begin
      finished = 1'b1;
      if (e_bit) begin
        mant_nx = {1'b1, mant_in[MANT_W-1:1]};
        exp_nx  = exp_in + 1'b1;
      end
    end else if (mant_in == '0) begin
      finished = 1'b1;
      sub_zero = 1'b1;
      sign_nx  = 1'b0;
      exp_nx   = '0;
    end else if (mant_in[MANT_W-1]) begin
      finished = 1'b1;
    end else if (exp_in == '0) begin
      finished  = 1'b1;
      uflow_hit = 1'b1;
    end else begin
      mant_nx = {mant_in[MANT_W-2:0], 1'b0};
      exp_nx  = exp_in - 1'b1;
    end
  end

endmodule

// File: rtl/fpas_seq.sv
module fpas_seq
  import fpas_pkg::*;
#(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_sub,
  input  logic              a_sign,
  input  logic [MANT_W-1:0] a_mant,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic              b_sign,
  input  logic [MANT_W-1:0] b_mant,
  input  logic [EXP_W-1:0]  b_exp,
  output logic              busy,
  output logic              done,
  output logic              r_sign,
  output logic [MANT_W-1:0] r_mant,
  output logic [EXP_W-1:0]  r_exp,
  output logic              exp_uflow
);

  fpas_state_e       state;
  logic              ac_sign, br_sign, op_q, e_q, add_q, done_q, uflow_q;
  logic [MANT_W-1:0] ac_mant, br_mant;
  logic [EXP_W-1:0]  ac_exp, br_exp;

  exp_cmp_e          cmp;
  logic [MANT_W-1:0] al_a_mant, al_b_mant;
  logic [EXP_W-1:0]  al_a_exp, al_b_exp;

  logic              alu_sign, alu_carry, alu_add;
  logic [MANT_W-1:0] alu_mant;

  logic              nm_sign, nm_fin, nm_zero, nm_uflow;
  logic [MANT_W-1:0] nm_mant;
  logic [EXP_W-1:0]  nm_exp;

  // Named internal events for the checker.
  logic ev_accept, ev_shift_a, ev_shift_b, ev_sub_zero;

  fpas_align #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
    .a_mant   (ac_mant),
    .a_exp    (ac_exp),
    .b_mant   (br_mant),
    .b_exp    (br_exp),
    .cmp      (cmp),
    .a_mant_nx(al_a_mant),
    .a_exp_nx (al_a_exp),
    .b_mant_nx(al_b_mant),
    .b_exp_nx (al_b_exp)
  );

  fpas_mant_alu #(.MANT_W(MANT_W)) u_alu (
    .a_sign  (ac_sign),
    .a_mant  (ac_mant),
    .b_sign  (br_sign),
    .b_mant  (br_mant),
    .op_sub  (op_q),
    .res_sign(alu_sign),
    .res_mant(alu_mant),
    .carry   (alu_carry),
    .did_add (alu_add)
  );

  fpas_norm #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_norm (
    .sign_in  (ac_sign),
    .mant_in  (ac_mant),
    .exp_in   (ac_exp),
    .e_bit    (e_q),
    .was_add  (add_q),
    .sign_nx  (nm_sign),
    .mant_nx  (nm_mant),
    .exp_nx   (nm_exp),
    .finished (nm_fin),
    .sub_zero (nm_zero),
    .uflow_hit(nm_uflow)
  );

  assign ev_accept   = (state == ST_IDLE) && start;
  assign ev_shift_a  = (state == ST_ALIGN) && (cmp == CMP_LT);
  assign ev_shift_b  = (state == ST_ALIGN) && (cmp == CMP_GT);
  assign ev_sub_zero = (state == ST_NORM) && nm_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ac_sign <= 1'b0;
      ac_mant <= '0;
      ac_exp  <= '0;
      br_sign <= 1'b0;
      br_mant <= '0;
      br_exp  <= '0;
      op_q    <= 1'b0;
      e_q     <= 1'b0;
      add_q   <= 1'b0;
      done_q  <= 1'b0;
      uflow_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            ac_sign <= a_sign;
            ac_mant <= a_mant;
            ac_exp  <= a_exp;
            br_sign <= b_sign;
            br_mant <= b_mant;
            br_exp  <= b_exp;
            op_q    <= op_sub;
            uflow_q <= 1'b0;
            state   <= ST_ZCHK;
          end
        end
        ST_ZCHK: begin
          if (br_mant == '0) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else if (ac_mant == '0) begin
            ac_sign <= br_sign ^ op_q;
            ac_mant <= br_mant;
            ac_exp  <= br_exp;
            done_q  <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            state <= ST_ALIGN;
          end
        end
        ST_ALIGN: begin
          if (cmp == CMP_EQ) begin
            state <= ST_ARITH;
          end else begin
            ac_mant <= al_a_mant;
            ac_exp  <= al_a_exp;
            br_mant <= al_b_mant;
            br_exp  <= al_b_exp;
          end
        end
        ST_ARITH: begin
          ac_sign <= alu_sign;
          ac_mant <= alu_mant;
          e_q     <= alu_carry;
          add_q   <= alu_add;
          state   <= ST_NORM;
        end
        ST_NORM: begin
          ac_sign <= nm_sign;
          ac_mant <= nm_mant;
          ac_exp  <= nm_exp;
          if (nm_uflow) uflow_q <= 1'b1;
          if (nm_fin) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign r_sign    = ac_sign;
  assign r_mant    = ac_mant;
  assign r_exp     = ac_exp;
  assign exp_uflow = uflow_q;

endmodule

// File: rtl/fpas_seq_chk.sv
module fpas_seq_chk #(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              exp_uflow,
  input logic              r_sign,
  input logic [MANT_W-1:0] r_mant,
  input logic [EXP_W-1:0]  r_exp,
  input logic [EXP_W-1:0]  br_exp,
  input logic              op_q,
  input logic              ev_accept,
  input logic              ev_shift_a,
  input logic              ev_shift_b,
  input logic              ev_sub_zero
);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> $past(start));

  p_op_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_q));

  p_align_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_shift_a |=> (r_exp == EXP_W'($past(r_exp) + 1'b1)) && $stable(br_exp));

  p_align_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_shift_b |=> (br_exp == EXP_W'($past(br_exp) + 1'b1)) && $stable(r_exp));

  p_zero_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sub_zero |=> (r_mant == '0) && (r_exp == '0) && !r_sign);

  p_normalized_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !exp_uflow && (r_mant != '0)) |-> r_mant[MANT_W-1]);

  p_uflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_uflow && !ev_accept) |=> exp_uflow);

  p_uflow_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !exp_uflow);

endmodule

bind fpas_seq fpas_seq_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .exp_uflow  (exp_uflow),
  .r_sign     (r_sign),
  .r_mant     (r_mant),
  .r_exp      (r_exp),
  .br_exp     (br_exp),
  .op_q       (op_q),
  .ev_accept  (ev_accept),
  .ev_shift_a (ev_shift_a),
  .ev_shift_b (ev_shift_b),
  .ev_sub_zero(ev_sub_zero)
);

// File: tb/fpas_seq_test.sv
module fpas_seq_test;

  localparam int MW = 8;
  localparam int EW = 6;
  localparam int VW = 47;
  localparam int NV = 12;

  // Vector layout: a_s a_m a_e b_s b_m b_e op | r_s r_m r_e uf
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 8'h80, 6'd10, 1'b0, 8'h80, 6'd10, 1'b0, 1'b0, 8'h80, 6'd11, 1'b0},
    {1'b0, 8'hC0, 6'd10, 1'b0, 8'h80, 6'd8,  1'b0, 1'b0, 8'hE0, 6'd10, 1'b0},
    {1'b0, 8'hA0, 6'd5,  1'b0, 8'hA0, 6'd5,  1'b1, 1'b0, 8'h00, 6'd0,  1'b0},
    {1'b0, 8'h80, 6'd5,  1'b0, 8'hC0, 6'd5,  1'b1, 1'b1, 8'h80, 6'd4,  1'b0},
    {1'b1, 8'h90, 6'd7,  1'b0, 8'h88, 6'd7,  1'b0, 1'b1, 8'h80, 6'd3,  1'b0},
    {1'b1, 8'hB0, 6'd9,  1'b0, 8'h00, 6'd3,  1'b0, 1'b1, 8'hB0, 6'd9,  1'b0},
    {1'b0, 8'h00, 6'd2,  1'b0, 8'hD0, 6'd12, 1'b1, 1'b1, 8'hD0, 6'd12, 1'b0},
    {1'b0, 8'h00, 6'd2,  1'b1, 8'h84, 6'd20, 1'b0, 1'b1, 8'h84, 6'd20, 1'b0},
    {1'b1, 8'h80, 6'd3,  1'b1, 8'hFF, 6'd6,  1'b0, 1'b1, 8'h87, 6'd7,  1'b0},
    {1'b0, 8'h80, 6'd1,  1'b0, 8'hB0, 6'd1,  1'b1, 1'b1, 8'h60, 6'd0,  1'b1},
    {1'b0, 8'h80, 6'd20, 1'b0, 8'h80, 6'd5,  1'b0, 1'b0, 8'h80, 6'd20, 1'b0},
    {1'b0, 8'h80, 6'd4,  1'b1, 8'h80, 6'd4,  1'b1, 1'b0, 8'h80, 6'd5,  1'b0}
  };

  string vtag [NV] = '{"R5", "R4", "R6", "R7", "R7", "R2",
                       "R3", "R3", "R4", "R8", "R4", "R5"};

  logic          clk = 1'b0;
  logic          rst_n, start, op_sub, a_sign, b_sign;
  logic [MW-1:0] a_mant, b_mant;
  logic [EW-1:0] a_exp, b_exp;
  logic          busy, done, r_sign, exp_uflow;
  logic [MW-1:0] r_mant;
  logic [EW-1:0] r_exp;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  fpas_seq #(.MANT_W(MW), .EXP_W(EW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
    .a_sign(a_sign), .a_mant(a_mant), .a_exp(a_exp),
    .b_sign(b_sign), .b_mant(b_mant), .b_exp(b_exp),
    .busy(busy), .done(done), .r_sign(r_sign), .r_mant(r_mant),
    .r_exp(r_exp), .exp_uflow(exp_uflow)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [VW-1:0] v);
    a_sign = v[46]; a_mant = v[45:38]; a_exp = v[37:32];
    b_sign = v[31]; b_mant = v[30:23]; b_exp = v[22:17];
    op_sub = v[16];
  endtask

  task automatic wait_done(input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk({tag, " done seen"}, int'(seen), 1);
  endtask

  task automatic check_result(input string tag, input logic [VW-1:0] v);
    chk({tag, " sign"}, int'(r_sign), int'(v[15]));
    chk({tag, " mant"}, int'(r_mant), int'(v[14:7]));
    chk({tag, " exp"},  int'(r_exp),  int'(v[6:1]));
    chk({tag, " uflow R8"}, int'(exp_uflow), int'(v[0]));
  endtask

  // Launch one operation at a negative edge; busy must be high one edge later.
  task automatic launch(input logic [VW-1:0] v);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", int'(busy), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    drive('0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 sign", int'(r_sign), 0);
    chk("R1 mant", int'(r_mant), 0);
    chk("R1 exp", int'(r_exp), 0);
    chk("R1 uflow", int'(exp_uflow), 0);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      launch(VEC[k]);
      wait_done(vtag[k]);
      chk("R9 busy low with done", int'(busy), 0);
      check_result(vtag[k], VEC[k]);
      @(negedge clk);
      chk("R9 done single pulse", int'(done), 0);
    end

    // R10: start with other operands while busy (long alignment in flight)
    launch(VEC[10]);
    drive(VEC[0]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 still busy", int'(busy), 1);
    wait_done("R10");
    check_result("R10", VEC[10]);
    repeat (3) @(negedge clk);
    chk("R10 no second run", int'(busy), 0);
    chk("R10 result kept", int'(r_exp), 20);

    // R8: flag set, then cleared by a following accepted start
    launch(VEC[9]);
    wait_done("R8 set");
    chk("R8 flag set", int'(exp_uflow), 1);
    launch(VEC[1]);
    chk("R8 flag cleared on start", int'(exp_uflow), 0);
    wait_done("R8 clear");
    check_result("R8 follow-up", VEC[1]);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule